// File: doc/BRIEF.md
# Triplicated Output Voting Stage

This block sits at the output of a triplicated design and turns three redundant copies of one multi-bit result into three output driver slots. Each slot carries its own bitwise majority voter, which produces the value the slot drives. Each slot also has its own minority voter, which compares the slot's own copy against the other two copies. Wherever the own copy disagrees at a bit, the minority voter lowers that bit's output enable. The three slots can therefore be wired to one shared external node. At every bit at least two drivers are enabled, and all enabled drivers carry the same value.

The pad cells that perform the actual high-impedance release sit outside this block. They use the per-bit data and enable pairs of each slot. Voting is fully combinational. The block also reports one mismatch flag per slot for monitoring. By default these flags are registered, so they are observed one clock after the copies change. A parameter selects an unregistered variant.

Top module: `tri_vote_out`

## Requirements
- R1: Every slot's data output equals the bitwise majority of the three copies: a bit is 1 when at least two copies hold 1 at that bit.
- R2: Bit i of slot k's enable (1 = drive, 0 = high impedance) is 0 exactly when copy k differs at bit i from both other copies, and 1 otherwise. Slots 0, 1 and 2 belong to copies a, b and c.
- R3: On every bit where slot k is enabled, its data equals copy k at that bit.
- R4: At every bit at least two slots are enabled, and all enabled slots drive the same value, so the shared node never has contending drivers.
- R5: Faults may affect different bit positions in different copies. The resolved shared node still equals the majority value at every bit.
- R6: Bit k of the mismatch flag vector is the OR over all bits of slot k's disagreements. It is 0 when slot k's enable is all ones.
- R7: With FLAG_REG = 1 (default), the flags reflect the copies sampled at the previous rising clock edge. While rst_n is low, the flags are 0.
- R8: The width parameter WIDTH defaults to 24 bits for every copy and slot port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| copy_a | input | WIDTH | Redundant copy 0 |
| copy_b | input | WIDTH | Redundant copy 1 |
| copy_c | input | WIDTH | Redundant copy 2 |
| slot0_data | output | WIDTH | Voted value driven by slot 0 |
| slot0_oe | output | WIDTH | Per-bit drive enable of slot 0 |
| slot1_data | output | WIDTH | Voted value driven by slot 1 |
| slot1_oe | output | WIDTH | Per-bit drive enable of slot 1 |
| slot2_data | output | WIDTH | Voted value driven by slot 2 |
| slot2_oe | output | WIDTH | Per-bit drive enable of slot 2 |
| mismatch | output | 3 | Per-slot disagreement flags, bit k for slot k |

## Verification
Slot data and enables are combinational. The bench therefore compares them with its model one time unit after driving the copies at a falling edge, within the same cycle. The mismatch flags pass through one register. The bench checks them one time unit after the next rising edge, against flags it computed from the copies applied before that edge. The bench resolves the shared node bit by bit from the enabled drivers. It counts the drivers and any contention instead of taking the value from the design.

// File: rtl/tri_vote_pkg.sv
package tri_vote_pkg;
  localparam int unsigned NUM_COPIES = 3;
  localparam int unsigned IDX_W = 2;

  function automatic int unsigned peer_idx(input int unsigned self_idx, input int unsigned step);
    return (self_idx + step) % NUM_COPIES;
  endfunction
endpackage

// File: rtl/bit_majority.sv
module bit_majority #(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  input  logic [WIDTH-1:0] in_z,
  output logic [WIDTH-1:0] voted
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign voted[i] = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
  end
endmodule

// File: rtl/minority_check.sv
module minority_check #(
  parameter int unsigned WIDTH = 24
) (
  input  logic [WIDTH-1:0] own,
  input  logic [WIDTH-1:0] peer_p,
  input  logic [WIDTH-1:0] peer_q,
  output logic [WIDTH-1:0] drive_en
);
  logic [WIDTH-1:0] odd_one;
  always_comb begin
    odd_one  = (own ^ peer_p) & (own ^ peer_q);
    drive_en = ~odd_one;
  end
endmodule

// File: rtl/vote_slot.sv
module vote_slot #(
  parameter int unsigned WIDTH = 24,
  parameter int unsigned SELF  = 0
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [tri_vote_pkg::NUM_COPIES-1:0][WIDTH-1:0] copies,
  output logic [WIDTH-1:0]                            data,
  output logic [WIDTH-1:0]                            oe,
  output logic                                        disagree
);
  import tri_vote_pkg::*;
  localparam int unsigned PEER_P = (SELF + 1) % NUM_COPIES;
  localparam int unsigned PEER_Q = (SELF + 2) % NUM_COPIES;

  bit_majority #(.WIDTH(WIDTH)) u_maj (
    .in_x (copies[0]),
    .in_y (copies[1]),
    .in_z (copies[2]),
    .voted(data)
  );

  minority_check #(.WIDTH(WIDTH)) u_min (
    .own     (copies[SELF]),
    .peer_p  (copies[PEER_P]),
    .peer_q  (copies[PEER_Q]),
    .drive_en(oe)
  );

  assign disagree = ~(&oe);

  // R3: an enabled bit of this slot carries its own copy (majority agrees)
  a_r3_enabled_matches_own: assert property (@(posedge clk) disable iff (!rst_n)
    ((data ^ copies[SELF]) & oe) == '0);

  // R2: a released bit is one where the own copy lost the vote
  a_r2_release_only_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (~oe & ~(data ^ copies[SELF])) == '0);
endmodule

// File: rtl/flag_stage.sv
module flag_stage #(
  parameter int unsigned N   = 3,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_in,
  output logic [N-1:0] flags_out
);
  if (REG) begin : g_reg
    logic [N-1:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else        held <= flags_in;
    end
    assign flags_out = held;
  end else begin : g_comb
    assign flags_out = flags_in;
  end
endmodule

// File: rtl/tri_vote_out.sv
module tri_vote_out #(
  parameter int unsigned WIDTH    = 24,
  parameter bit          FLAG_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] copy_a,
  input  logic [WIDTH-1:0] copy_b,
  input  logic [WIDTH-1:0] copy_c,
  output logic [WIDTH-1:0] slot0_data,
  output logic [WIDTH-1:0] slot0_oe,
  output logic [WIDTH-1:0] slot1_data,
  output logic [WIDTH-1:0] slot1_oe,
  output logic [WIDTH-1:0] slot2_data,
  output logic [WIDTH-1:0] slot2_oe,
  output logic [2:0]       mismatch
);
  import tri_vote_pkg::*;

  logic [NUM_COPIES-1:0][WIDTH-1:0] copies;
  logic [NUM_COPIES-1:0][WIDTH-1:0] s_data;
  logic [NUM_COPIES-1:0][WIDTH-1:0] s_oe;
  logic [NUM_COPIES-1:0]            s_dis;

  assign copies[0] = copy_a;
  assign copies[1] = copy_b;
  assign copies[2] = copy_c;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_slot
    vote_slot #(.WIDTH(WIDTH), .SELF(k)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .copies  (copies),
      .data    (s_data[k]),
      .oe      (s_oe[k]),
      .disagree(s_dis[k])
    );
  end

  flag_stage #(.N(NUM_COPIES), .REG(FLAG_REG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_in (s_dis),
    .flags_out(mismatch)
  );

  assign slot0_data = s_data[0];
  assign slot0_oe   = s_oe[0];
  assign slot1_data = s_data[1];
  assign slot1_oe   = s_oe[1];
  assign slot2_data = s_data[2];
  assign slot2_oe   = s_oe[2];

  // R4: at least two drivers enabled at every bit
  a_r4_two_drivers: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_oe[0] & s_oe[1]) | (s_oe[0] & s_oe[2]) | (s_oe[1] & s_oe[2])) == {WIDTH{1'b1}});

  // R4: enabled drivers never contend
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (((s_data[0] ^ s_data[1]) & s_oe[0] & s_oe[1]) |
     ((s_data[0] ^ s_data[2]) & s_oe[0] & s_oe[2]) |
     ((s_data[1] ^ s_data[2]) & s_oe[1] & s_oe[2])) == '0);

  // R7: identical copies leave every flag clear
  if (FLAG_REG) begin : g_chk_reg
    a_r7_clean_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_a == copy_b && copy_b == copy_c) |=> (mismatch == 3'b000));
  end else begin : g_chk_comb
    a_r7_clean_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (copy_a == copy_b && copy_b == copy_c) |-> (mismatch == 3'b000));
  end
endmodule

// File: tb/tri_vote_out_test.sv
module tri_vote_out_test;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] ca = '0, cb = '0, cc = '0;
  logic [W-1:0] d0, d1, d2, e0, e1, e2;
  logic [2:0] mm;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tri_vote_out uut (
    .clk(clk), .rst_n(rst_n), .copy_a(ca), .copy_b(cb), .copy_c(cc),
    .slot0_data(d0), .slot0_oe(e0), .slot1_data(d1), .slot1_oe(e1),
    .slot2_data(d2), .slot2_oe(e2), .mismatch(mm)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] maj, da, db, dc, node, bad;
    logic [2:0] exp_flags;
    @(negedge clk);
    ca = a; cb = b; cc = c;
    #1;
    for (int i = 0; i < W; i++) begin
      int ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
      maj[i] = (ones >= 2);
      da[i] = (a[i] != maj[i]);
      db[i] = (b[i] != maj[i]);
      dc[i] = (c[i] != maj[i]);
    end
    chk("R1 slot0", d0, maj);
    chk("R1 slot1", d1, maj);
    chk("R1 slot2", d2, maj);
    chk("R2 slot0", e0, ~da);
    chk("R2 slot1", e1, ~db);
    chk("R2 slot2", e2, ~dc);
    chk("R3 slot0", d0 & e0, a & e0);
    chk("R3 slot1", d1 & e1, b & e1);
    chk("R3 slot2", d2 & e2, c & e2);
    // R4/R5: resolve the shared node bit by bit
    bad = '0;
    for (int i = 0; i < W; i++) begin
      int drivers = 0;
      int highs = 0;
      if (e0[i]) begin drivers++; highs += int'(d0[i]); end
      if (e1[i]) begin drivers++; highs += int'(d1[i]); end
      if (e2[i]) begin drivers++; highs += int'(d2[i]); end
      node[i] = (highs != 0);
      if (drivers < 2 || (highs != 0 && highs != drivers)) bad[i] = 1'b1;
    end
    chk("R4 contention", bad, '0);
    chk("R5 node", node, maj);
    exp_flags = {|dc, |db, |da};
    @(posedge clk);
    #1;
    chk("R6 R7 flags", {{(W-3){1'b0}}, mm}, {{(W-3){1'b0}}, exp_flags});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] base;
    // R7: flags held clear in reset even with disagreeing copies
    ca = 24'h00000F; cb = 24'h0000F0; cc = 24'h000F00;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset", {{(W-3){1'b0}}, mm}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: default width
    chk("R8 width", W'($bits(d0)), W'(24));
    // clean patterns
    apply('0, '0, '0);
    apply('1, '1, '1);
    for (int n = 0; n < 8; n++) begin
      base = W'($urandom);
      apply(base, base, base);
    end
    // every single-copy single-bit error
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < W; i++) begin
        base = W'($urandom);
        case (k)
          0: apply(base ^ (W'(1) << i), base, base);
          1: apply(base, base ^ (W'(1) << i), base);
          default: apply(base, base, base ^ (W'(1) << i));
        endcase
      end
    end
    // multi-bit errors confined to one copy
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] fl;
      base = W'($urandom);
      fl = W'($urandom) | W'(1);
      case (n % 3)
        0: apply(base ^ fl, base, base);
        1: apply(base, base ^ fl, base);
        default: apply(base, base, base ^ fl);
      endcase
    end
    // R5: faults at distinct bits in different copies
    for (int n = 0; n < 20; n++) begin
      int i = n % W;
      int j = (n + 7) % W;
      int m = (n + 15) % W;
      base = W'($urandom);
      apply(base ^ (W'(1) << i), base ^ (W'(1) << j), base ^ (W'(1) << m));
    end
    // arbitrary triples
    for (int n = 0; n < 30; n++) apply(W'($urandom), W'($urandom), W'($urandom));
    // return to clean: flags must clear (R6)
    apply(24'hA5A5A5, 24'hA5A5A5, 24'hA5A5A5);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule